// File: doc/BRIEF.md
# Shared Interrupt Line Aggregator

This block gathers a wide set of peripheral interrupt sources into pending status words and funnels them onto four shared CPU interrupt lines. Every source has one pending bit. The bit is set when the source fires and stays set until software clears it. The pending words are common to all output lines. Each line owns a private bank of enable words, so software steers a source to a line by setting that source's bit in that line's bank.

Bit 0 of the first enable word in each bank is not a source enable. It is a line-wide master enable, and it is ANDed with everything else in that bank. Each line output is a registered level that the CPU treats as an edge. When software turns the master enable off and then on again, the line drops and rises again if anything routed to it is still pending. A handler uses this to get a fresh edge after servicing. Software reaches all state through a flat word-addressed register port. Writes take effect in one cycle and reads are combinational.

Top module: `irq_share_agg`

## Requirements
- R1: A pending bit is set on any cycle in which its source input is high, whatever the enables hold. It stays set until software clears it, so a source that fired while it was disabled is delivered as soon as it is enabled.
- R2: Writing to clear address NUM_WORDS+w clears every pending bit of word w that is written as 1. Bits written as 0 are left untouched.
- R3: If a source is high in the same cycle that software clears its pending bit, the bit stays pending.
- R4: Address w (w below NUM_WORDS) reads pending word w, where source i sits at word i/32, bit i%32. Writes to status addresses change nothing. Clear addresses read as zero.
- R5: Address 2*NUM_WORDS + l*NUM_WORDS + w is enable word w of line l. It is readable and writable, and it is independent of the other lines' banks.
- R6: Line l is active when its master enable (bit 0 of its enable word 0) is set and at least one pending bit is set whose enable bit in bank l is also set.
- R7: Each output line rises on the first clock edge after its condition becomes true and falls on the first edge after it becomes false.
- R8: Clearing a line's master enable drops that line. Setting it again while a routed source is still pending raises the line again.
- R9: One source can be routed to several lines at once, and each line reacts only to its own bank.
- R10: After reset, all pending bits, all enable words and all master enables are zero, and all output lines are low.
- R11: Source 0 (word 0, bit 0) latches and can be read, but it never drives a line, because its enable position is taken by the master enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_irq | input | NUM_WORDS*WORD_W | Source interrupt inputs, sampled each cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | WORD_W | Write data |
| reg_rdata | output | WORD_W | Read data for reg_addr, combinational |
| irq_line | output | NUM_LINES | Shared interrupt lines to the CPU |

## Verification
The bench targets the master-enable retoggle. A design that fails it would leave the line stuck high, or would leave it low after re-enabling. It also targets a source firing in the same cycle its bit is cleared; a design that lets the clear win loses that interrupt. A source that fires while disabled must still be delivered when it is enabled later, and a design without a sticky latch drops it. The remaining targets are:
- a partial clear, where a design that clears whole words wipes out unrelated pending bits;
- source 0, which must never drive a line;
- the one-cycle rise and fall of the output;
- routing one source to two lines at once.

// File: rtl/irq_share_pkg.sv
// Shared types for the interrupt line aggregator.
// Assumes: address decode results fit in 8-bit line and word indices.
package irq_share_pkg;

    // Register region selected by an address
    typedef enum logic [1:0] {
        RGN_STATUS = 2'd0,
        RGN_CLEAR  = 2'd1,
        RGN_ENABLE = 2'd2,
        RGN_NONE   = 2'd3
    } rgn_e;

    // Decoded register address
    typedef struct packed {
        rgn_e       rgn;
        logic [7:0] line;
        logic [7:0] word;
    } dec_t;

endpackage

// File: rtl/irq_pend_bank.sv
// Pending bit store: one sticky bit per source.
// A source that is high in a cycle sets its bit. A clear mask bit resets it
// unless the source is also high in that cycle, in which case the set wins.
// Assumes: clr_mask is already decoded from a write-one-to-clear access.
module irq_pend_bank #(
    parameter int NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_irq,
    input  logic [NUM_SRC-1:0] clr_mask,
    output logic [NUM_SRC-1:0] pend
);

    // Latch new sources, drop cleared bits, new assertions take priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            pend <= (pend & ~clr_mask) | src_irq;
        end
    end

endmodule

// File: rtl/irq_en_bank.sv
// Enable word store for every output line.
// Flat layout: line l, word w occupies bits (l*NUM_WORDS+w)*WORD_W upward,
// so line l's per-source enables form one NUM_WORDS*WORD_W slice.
// Assumes: line_sel/word_sel are valid whenever wr is high.
module irq_en_bank #(
    parameter int NUM_LINES = 4,
    parameter int NUM_WORDS = 2,
    parameter int WORD_W    = 32,
    localparam int TOTAL_W  = NUM_LINES * NUM_WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [7:0]        line_sel,
    input  logic [7:0]        word_sel,
    input  logic [WORD_W-1:0] wdata,
    output logic [TOTAL_W-1:0] en
);

    // Update the addressed enable word; all words clear in reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= '0;
        end else if (wr) begin
            for (int l = 0; l < NUM_LINES; l++) begin
                for (int w = 0; w < NUM_WORDS; w++) begin
                    if (int'(line_sel) == l && int'(word_sel) == w) begin
                        en[(l*NUM_WORDS+w)*WORD_W +: WORD_W] <= wdata;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/irq_line_gate.sv
// One output line: masks the pending bits with the line's enables, gates
// the result with the master enable (enable bit 0) and registers it.
// Assumes: position 0 of en is the master enable, never a source enable.
module irq_line_gate #(
    parameter int NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] en,
    output logic               cond,
    output logic               irq
);

    localparam logic [NUM_SRC-1:0] ROUTE_MASK = {{(NUM_SRC-1){1'b1}}, 1'b0};

    logic master;
    logic any_hit;

    // Combine routed pending bits and apply the line-wide gate
    always_comb begin
        master  = en[0];
        any_hit = |(pend & en & ROUTE_MASK);
        cond    = master & any_hit;
    end

    // Register the condition into the visible line level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= cond;
        end
    end

endmodule

// File: rtl/irq_share_agg.sv
// Top of the shared interrupt line aggregator.
// Decodes a flat word address into status, clear and enable regions,
// feeds the pending store and the enable store, and builds one gate per line.
// Assumes: single-cycle writes; reads are combinational from reg_addr.
module irq_share_agg
    import irq_share_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int NUM_WORDS = 2,
    parameter int WORD_W    = 32,
    localparam int NUM_SRC  = NUM_WORDS * WORD_W,
    localparam int NUM_REGS = 2 * NUM_WORDS + NUM_LINES * NUM_WORDS,
    localparam int ADDR_W   = $clog2(NUM_REGS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   src_irq,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata,
    output logic [NUM_LINES-1:0] irq_line
);

    localparam int CLR_BASE = NUM_WORDS;
    localparam int EN_BASE  = 2 * NUM_WORDS;
    localparam int EN_END   = EN_BASE + NUM_LINES * NUM_WORDS;

    dec_t                            dec;
    logic [NUM_SRC-1:0]              clr_mask;
    logic [NUM_SRC-1:0]              pend_q;
    logic [NUM_LINES*NUM_SRC-1:0]    en_flat;
    logic [NUM_LINES-1:0]            line_cond;
    logic                            en_wr;

    // Map the flat address onto a region plus line and word index
    always_comb begin
        int a;
        a   = int'(reg_addr);
        dec = '{rgn: RGN_NONE, line: 8'd0, word: 8'd0};
        if (a < CLR_BASE) begin
            dec.rgn  = RGN_STATUS;
            dec.word = 8'(a);
        end else if (a < EN_BASE) begin
            dec.rgn  = RGN_CLEAR;
            dec.word = 8'(a - CLR_BASE);
        end else if (a < EN_END) begin
            dec.rgn  = RGN_ENABLE;
            dec.line = 8'((a - EN_BASE) / NUM_WORDS);
            dec.word = 8'((a - EN_BASE) % NUM_WORDS);
        end
    end

    // Expand a clear-region write into a per-source clear mask
    always_comb begin
        clr_mask = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (reg_wr && dec.rgn == RGN_CLEAR && int'(dec.word) == w) begin
                clr_mask[w*WORD_W +: WORD_W] = reg_wdata;
            end
        end
    end

    // Enable-region write strobe
    always_comb en_wr = reg_wr && (dec.rgn == RGN_ENABLE);

    irq_pend_bank #(
        .NUM_SRC (NUM_SRC)
    ) pend_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_irq  (src_irq),
        .clr_mask (clr_mask),
        .pend     (pend_q)
    );

    irq_en_bank #(
        .NUM_LINES (NUM_LINES),
        .NUM_WORDS (NUM_WORDS),
        .WORD_W    (WORD_W)
    ) en_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (en_wr),
        .line_sel (dec.line),
        .word_sel (dec.word),
        .wdata    (reg_wdata),
        .en       (en_flat)
    );

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        irq_line_gate #(
            .NUM_SRC (NUM_SRC)
        ) gate_i (
            .clk   (clk),
            .rst_n (rst_n),
            .pend  (pend_q),
            .en    (en_flat[l*NUM_SRC +: NUM_SRC]),
            .cond  (line_cond[l]),
            .irq   (irq_line[l])
        );
    end

    // Select read data; clear region and unmapped addresses read zero
    always_comb begin
        reg_rdata = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (dec.rgn == RGN_STATUS && int'(dec.word) == w) begin
                reg_rdata = pend_q[w*WORD_W +: WORD_W];
            end
            for (int l = 0; l < NUM_LINES; l++) begin
                if (dec.rgn == RGN_ENABLE && int'(dec.word) == w &&
                    int'(dec.line) == l) begin
                    reg_rdata = en_flat[(l*NUM_WORDS+w)*WORD_W +: WORD_W];
                end
            end
        end
    end

endmodule

// File: rtl/irq_share_agg_chk.sv
// Assertion checker for irq_share_agg, attached by bind.
// Observes ports plus the pending store and per-line conditions.
module irq_share_agg_chk #(
    parameter int NUM_LINES = 4,
    parameter int NUM_WORDS = 2,
    parameter int WORD_W    = 32,
    localparam int NUM_SRC  = NUM_WORDS * WORD_W,
    localparam int ADDR_W   = $clog2(2 * NUM_WORDS + NUM_LINES * NUM_WORDS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_SRC-1:0]   src_irq,
    input logic                 reg_wr,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [WORD_W-1:0]    reg_wdata,
    input logic [NUM_SRC-1:0]   pend,
    input logic [NUM_LINES-1:0] line_cond,
    input logic [NUM_LINES-1:0] irq_line
);

    logic [NUM_SRC-1:0] clr_req;

    // Rebuild the requested clear bits from the register port
    always_comb begin
        clr_req = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (reg_wr && int'(reg_addr) == NUM_WORDS + w) begin
                clr_req[w*WORD_W +: WORD_W] = reg_wdata;
            end
        end
    end

    // R1
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((pend & $past(pend & ~clr_req)) == $past(pend & ~clr_req)));

    // R3
    src_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_irq != '0) |=> ((pend & $past(src_irq)) == $past(src_irq)));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (irq_line == '0 && pend == '0));

    // R11
    src0_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend >> 1) == '0) |-> (line_cond == '0));

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line_chk
        // R7
        line_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            line_cond[l] |=> irq_line[l]);
        // R7
        line_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !line_cond[l] |=> !irq_line[l]);
    end

endmodule

bind irq_share_agg irq_share_agg_chk #(
    .NUM_LINES (NUM_LINES),
    .NUM_WORDS (NUM_WORDS),
    .WORD_W    (WORD_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_irq   (src_irq),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .pend      (pend_q),
    .line_cond (line_cond),
    .irq_line  (irq_line)
);

// File: tb/irq_share_agg_tb.sv
// Self-checking bench for irq_share_agg: vector table then directed cases.
module irq_share_agg_tb_top;

    localparam int NL = 4;
    localparam int NW = 2;
    localparam int WW = 32;
    localparam int NS = NL * 0 + NW * WW;
    localparam int AW = $clog2(2 * NW + NL * NW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_irq = '0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [WW-1:0] reg_wdata = '0;
    logic [WW-1:0] reg_rdata;
    logic [NL-1:0] irq_line;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    irq_share_agg #(.NUM_LINES(NL), .NUM_WORDS(NW), .WORD_W(WW)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_line(irq_line)
    );

    // Vector: {line[1:0], source[5:0], expected lines[3:0]}
    localparam logic [11:0] VEC [8] = '{
        {2'd0, 6'd5,  4'b0001},
        {2'd1, 6'd40, 4'b0010},
        {2'd2, 6'd31, 4'b0100},
        {2'd3, 6'd63, 4'b1000},
        {2'd3, 6'd32, 4'b1000},
        {2'd0, 6'd0,  4'b0000},
        {2'd2, 6'd1,  4'b0100},
        {2'd1, 6'd33, 4'b0010}
    };

    function automatic logic [AW-1:0] a_st(int w); return AW'(w); endfunction
    function automatic logic [AW-1:0] a_cl(int w); return AW'(NW + w); endfunction
    function automatic logic [AW-1:0] a_en(int l, int w); return AW'(2*NW + l*NW + w); endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [WW-1:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [WW-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input int idx);
        src_irq = '0;
        src_irq[idx] = 1'b1;
        tick();
        src_irq = '0;
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clear_all();
        wr(a_cl(0), '1);
        wr(a_cl(1), '1);
    endtask

    initial begin
        #800000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [WW-1:0] d;
        tick(); tick();
        // R10 reset state
        check("R10 lines after reset", 64'(irq_line), 0);
        rd(a_st(0), d); check("R10 status0 after reset", 64'(d), 0);
        rd(a_en(2, 1), d); check("R10 enable after reset", 64'(d), 0);
        rst_n = 1'b1;
        tick();

        // R4 status writes ignored, clear region reads zero
        wr(a_st(0), 32'hFFFF_FFFF);
        rd(a_st(0), d); check("R4 status write ignored", 64'(d), 0);
        rd(a_cl(1), d); check("R4 clear reads zero", 64'(d), 0);

        // Master enables on for all lines
        for (int l = 0; l < NL; l++) wr(a_en(l, 0), 32'h1);

        // R6 R9 vector walk
        for (int i = 0; i < 8; i++) begin
            int ln; int sr; int wd; int bt;
            ln = int'(VEC[i][11:10]); sr = int'(VEC[i][9:4]);
            wd = sr / WW; bt = sr % WW;
            wr(a_en(ln, wd), (32'h1 << bt) | (wd == 0 ? 32'h1 : 32'h0));
            pulse(sr);
            tick();
            check($sformatf("R6 vector %0d lines", i), 64'(irq_line), 64'(VEC[i][3:0]));
            clear_all();
            wr(a_en(ln, wd), (wd == 0) ? 32'h1 : 32'h0);
            tick();
        end

        // R1 pending while disabled, delivered once enabled; R7 latency
        pulse(7);
        tick();
        check("R1 disabled source not delivered", 64'(irq_line), 0);
        rd(a_st(0), d); check("R1 pending latched while disabled", 64'(d), 64'h80);
        wr(a_en(0, 0), 32'h81);
        check("R7 line still low right after enable", 64'(irq_line), 0);
        tick();
        check("R1 delivered after enable", 64'(irq_line), 64'h1);

        // R8 master retoggle
        wr(a_en(0, 0), 32'h80);
        tick();
        check("R8 master off drops line", 64'(irq_line), 0);
        wr(a_en(0, 0), 32'h81);
        tick();
        check("R8 master on raises line again", 64'(irq_line), 64'h1);

        // R2 partial clear
        pulse(9);
        wr(a_cl(0), 32'h200);
        rd(a_st(0), d); check("R2 zero bits untouched", 64'(d), 64'h80);

        // R3 same-cycle set beats clear
        src_irq = '0; src_irq[9] = 1'b1;
        wr(a_cl(0), 32'h280);
        src_irq = '0;
        rd(a_st(0), d); check("R3 set wins over clear", 64'(d), 64'h200);
        clear_all();
        wr(a_en(0, 0), 32'h1);
        tick();

        // R9 one source on two lines; R5 bank independence
        wr(a_en(1, 1), 32'h100);
        wr(a_en(3, 1), 32'h100);
        pulse(40);
        tick();
        check("R9 source on lines 1 and 3", 64'(irq_line), 64'hA);
        rd(a_en(3, 1), d); check("R5 enable readback", 64'(d), 64'h100);
        rd(a_en(2, 1), d); check("R5 other bank untouched", 64'(d), 0);

        // R7 fall timing
        wr(a_cl(1), 32'h100);
        check("R7 line holds one cycle after clear", 64'(irq_line), 64'hA);
        tick();
        check("R7 line falls next edge", 64'(irq_line), 0);

        // R11 source 0 never routes
        wr(a_en(0, 0), 32'hFFFF_FFFF);
        pulse(0);
        tick(); tick();
        check("R11 source 0 silent", 64'(irq_line), 0);
        rd(a_st(0), d); check("R11 source 0 latched", 64'(d), 64'h1);

        // R10 reset mid-run
        pulse(4);
        tick();
        check("R10 pre-reset line high", 64'(irq_line), 64'h1);
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        check("R10 line low after reset", 64'(irq_line), 0);
        rd(a_st(0), d); check("R10 pending cleared", 64'(d), 0);
        rd(a_en(0, 0), d); check("R10 enables cleared", 64'(d), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule